// File: doc/BRIEF.md
# Load-Align Shift-Insert Register Unit

This datapath block merges one freshly loaded memory element into a 64-bit destination value. The old value slides toward the least significant end by the width of the element, and the new element lands in the most significant bits. Repeated loads therefore turn the destination into a sliding window over memory: the most recent element sits at the top, and the oldest element falls off the bottom.

Two element widths are supported, a byte and a halfword. A halfword arrives little-endian on the data input: the byte from the lower address is in bits 7:0. The merged value is produced combinationally from the current destination presented on the input. The same value is captured into an internal register on every strobed cycle. A caller that wants to accumulate a stream feeds the held value back as the current destination. Address generation, memory access and register-file porting stay outside this block.

Top module: `ldalign_window`

## Requirements
- R1: A synchronous reset (`rst` high at a rising clock edge) sets `held_o` to zero.
- R2: With `half_i` = 0 (byte), `merged_o` equals `{data_i[7:0], cur_i[63:8]}`.
- R3: With `half_i` = 1 (halfword), `merged_o` equals `{data_i[15:0], cur_i[63:16]}`, with `data_i[7:0]` being the lower-address byte.
- R4: In byte mode, `data_i[15:8]` has no effect on `merged_o`. No sign or zero extension is applied to the element.
- R5: When `valid_i` is low at a clock edge, `held_o` keeps its value.
- R6: When `valid_i` is high at a clock edge (and no reset), `held_o` takes the value `merged_o` had in that cycle.
- R7: Starting from all ones and feeding back `held_o`, byte loads 0x01, 0x02, 0x03, 0x04 leave 0x04030201ffffffff.
- R8: Starting from all ones and feeding back, halfword loads 0x0201, 0x0403, 0x0605, 0x0807 leave 0x0807060504030201.
- R9: Mixed widths chain correctly. From all ones, the loads byte 0xAA, then half 0x2211, then byte 0x33 leave 0x332211aaffffffff.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Element strobe; captures the merged value |
| half_i | input | 1 | Element size: 0 = byte, 1 = halfword |
| data_i | input | 16 | Loaded element, little-endian; byte mode uses bits 7:0 |
| cur_i | input | 64 | Current destination value |
| merged_o | output | 64 | Destination after shift and insert (combinational) |
| held_o | output | 64 | Registered merged value from the last strobed cycle |

## Verification
Every cycle, the embedded assertions confirm several properties. The surviving part of the old value is the correctly shifted slice of `cur_i` for the selected width. In byte mode the top byte is exactly `data_i[7:0]`. The register holds when not strobed, captures the merged value when strobed, and clears after reset. Only the bench scenarios show the accumulated window contents over a stream of loads. These are the full-byte and full-halfword sequences, the mixed-width chain, and the case where junk in the unused upper data byte is discarded. They rely on the bench's own model of the held value, which is compared on every clock.

// File: rtl/ldalign_window.sv
module ldalign_window #(
  parameter int DW = 64,
  parameter int EW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          valid_i,
  input  logic          half_i,
  input  logic [2*EW-1:0] data_i,
  input  logic [DW-1:0] cur_i,
  output logic [DW-1:0] merged_o,
  output logic [DW-1:0] held_o
);
  localparam int HW = 2 * EW;

  logic [DW-1:0] by_byte, by_half;

  assign by_byte  = {data_i[EW-1:0], cur_i[DW-1:EW]};
  assign by_half  = {data_i, cur_i[DW-1:HW]};
  assign merged_o = half_i ? by_half : by_byte;

  always_ff @(posedge clk) begin
    if (rst)          held_o <= '0;
    else if (valid_i) held_o <= merged_o;
  end

  always_comb begin
    if (!half_i) begin
      assert_byte_shift_R2: assert (merged_o[DW-EW-1:0] == cur_i[DW-1:EW]);
      assert_byte_top_R4: assert (merged_o[DW-1:DW-EW] == data_i[EW-1:0]);
    end else begin
      assert_half_shift_R3: assert (merged_o[DW-HW-1:0] == cur_i[DW-1:HW]);
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk) rst |=> held_o == '0);

  assert_hold_idle_R5: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> $stable(held_o));

  assert_capture_R6: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> held_o == $past(merged_o));
endmodule

// File: tb/tb_ldalign_window.sv
module tb_ldalign_window;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst = 1;
  logic        valid_i = 0;
  logic        half_i = 0;
  logic [15:0] data_i = '0;
  logic [63:0] cur_i = '0;
  logic [63:0] merged_o, held_o;

  int checks = 0;
  int fails = 0;
  longint unsigned model_held = 0;
  bit model_live = 0;

  ldalign_window dut (
    .clk(clk), .rst(rst), .valid_i(valid_i), .half_i(half_i),
    .data_i(data_i), .cur_i(cur_i), .merged_o(merged_o), .held_o(held_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic longint unsigned ref_merge(longint unsigned cur, bit h, int unsigned d);
    if (h) return (cur >> 16) | (longint'(d & 16'hffff) << 48);
    return (cur >> 8) | (longint'(d & 8'hff) << 56);
  endfunction

  // behavioural reference for the held value (R1, R5, R6)
  always @(posedge clk) begin
    if (rst) begin
      model_held = 0;
      model_live = 1;
    end else if (valid_i) begin
      model_held = ref_merge(cur_i, half_i, data_i);
    end
  end

  always @(negedge clk)
    if (model_live) chk("R6/R5 per-cycle held", held_o, model_held);

  task automatic step(input bit v, input bit h, input logic [15:0] d,
                      input bit fb, input string req);
    @(negedge clk);
    valid_i = v; half_i = h; data_i = d;
    cur_i = fb ? held_o : '1;
    #1;
    chk(req, merged_o, ref_merge(cur_i, h, d));
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 reset value", held_o, 64'h0);

    // R1: reset clears a nonzero held value
    step(1, 1, 16'hbeef, 0, "R3 pre-reset");
    @(negedge clk); rst = 0;
    step(1, 1, 16'h1234, 0, "R3 load");
    @(negedge clk); valid_i = 0; rst = 1;
    @(negedge clk); rst = 0;
    chk("R1 reset after load", held_o, 64'h0);

    // R2 byte sequence, R7
    step(1, 0, 16'h0001, 0, "R2 byte 1");
    step(1, 0, 16'h0002, 1, "R2 byte 2");
    step(1, 0, 16'h0003, 1, "R2 byte 3");
    step(1, 0, 16'h0004, 1, "R2 byte 4");
    @(negedge clk); valid_i = 0;
    chk("R7 byte window", held_o, 64'h04030201ffffffff);

    // R5: idle cycles with changing inputs
    data_i = 16'h5555; half_i = 1; cur_i = 64'h0;
    repeat (3) @(negedge clk);
    chk("R5 held while idle", held_o, 64'h04030201ffffffff);

    // R3 halfword sequence, R8
    step(1, 1, 16'h0201, 0, "R3 half 1");
    step(1, 1, 16'h0403, 1, "R3 half 2");
    step(1, 1, 16'h0605, 1, "R3 half 3");
    step(1, 1, 16'h0807, 1, "R3 half 4");
    @(negedge clk); valid_i = 0;
    chk("R8 half window", held_o, 64'h0807060504030201);

    // R4: upper data byte ignored in byte mode
    step(1, 0, 16'hee01, 0, "R4 byte with junk");
    chk("R4 top byte", merged_o, 64'h01ffffffffffffff);
    @(negedge clk); valid_i = 0;
    chk("R4 held", held_o, 64'h01ffffffffffffff);

    // R9 mixed widths
    step(1, 0, 16'h00aa, 0, "R9 byte aa");
    step(1, 1, 16'h2211, 1, "R9 half 2211");
    step(1, 0, 16'hff33, 1, "R9 byte 33");
    @(negedge clk); valid_i = 0;
    chk("R9 mixed window", held_o, 64'h332211aaffffffff);

    @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule